// File: doc/BRIEF.md
# ECC DRAM Cycle Sequencer

This block sits between a host port and a 16-bit DRAM array whose every word is stored with six check bits, 22 bits in all. It takes word reads, word writes, byte writes and its own periodic refreshes, picks one at a time, and runs the chosen cycle as a series of steps. A step counter and a cycle-type code address two tables. One table gives each step's length in clock cycles. The other gives that step's row strobe, column strobe, write enable, data-drive enable and read-latch enable.

A byte write is never sent to the array as a byte. The block reads the full word, corrects it if correction is on, merges in the new byte, and writes back the whole word with freshly computed check bits. Correction starts out disabled and is switched on or off by a control write. While it is on, reads fix single-bit errors and set sticky error flags.

The array is split into banks that are interleaved on the low word-address bits. Refresh cycles strobe every bank at once, using a rolling row counter. Refresh keeps running while the system reset is held, so the stored data survives a reset. Only the power-on reset stops the sequencer.

Top module: `ecc_dram_seq`

## Requirements
- R1: After power-on reset, all row strobes, the column strobe and write enable are inactive (high), `busy` is 0, both error flags are 0, and correction is disabled.
- R2: A word written and then read back at the same address returns the written 16 bits. In the stored codeword, check bits sit at positions 0, 1, 2, 4, 8 and 16, and data bits 0 to 15 fill the remaining positions in ascending order, so data bit 0 is at position 3.
- R3: With correction enabled, a read of a word with any one stored bit flipped returns the original data and sets `err_corr`. The flag stays set until the next control write.
- R4: With correction enabled, a read of a word with two stored bits flipped sets `err_uncorr`, which is sticky in the same way.
- R5: With correction disabled, a read returns the raw stored data bits with no correction, and neither error flag changes.
- R6: A byte write (`req_hi`=1 selects bits 15:8, 0 selects bits 7:0) changes only that byte. The other byte is kept, and the check bits written cover the merged word, so a later corrected read reports no error.
- R7: Step lengths follow the tables. A read holds the column strobe low for T_CAS+1 cycles with write enable high. A word write holds it low for T_CAS cycles with write enable low. A byte write produces a read pulse of T_CAS+1 cycles followed by a write pulse of T_CAS cycles.
- R8: A refresh cycle pulls every row strobe low together while the column strobe stays high, and such cycles recur within each REF_INT-cycle interval. They continue while `sys_rst` is high, and during that time host requests are dropped (`busy` stays 0).
- R9: The bank is given by word-address bits [1:0], the column by bits [5:2] and the row by bits [9:6] (default sizes). A host cycle lowers only that bank's row strobe.
- R10: Data written before a `sys_rst` pulse reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; resets everything |
| sys_rst | input | 1 | System reset; drops host requests, refresh continues |
| req_valid | input | 1 | Host request strobe, taken when `busy` is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte write (read-modify-write) |
| req_hi | input | 1 | Byte lane for byte writes: 1 = bits 15:8 |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| cfg_we | input | 1 | Control register write; also clears both error flags |
| cfg_ecc_en | input | 1 | Correction enable value for `cfg_we` |
| busy | output | 1 | Host request pending or running |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data |
| err_corr | output | 1 | Sticky single-bit error seen |
| err_uncorr | output | 1 | Sticky uncorrectable error seen |
| dram_ras_n | output | NB | Per-bank row strobes, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_row | output | ROW_W | Row address |
| dram_col | output | COL_W | Column address |
| dram_wdata | output | 22 | Codeword to array |
| dram_dout_en | output | 1 | Drive `dram_wdata` onto the array |
| dram_rdata | input | 22 | Codeword from array |

## Verification
A wrong step counter or table entry shows up at once as a column-strobe pulse of the wrong length, or a write enable outside its column pulse, during the cycle that is running. The strobe-run monitor sees it at the end of that pulse. A fault in the merge or check-bit path is silent when the byte write happens. It shows up only at the next corrected read of that word, as a set flag or wrong data. For that reason every byte write is read back with correction enabled. A broken refresh timer or reset gating shows up within one refresh interval, as a missing all-bank strobe or as `busy` rising while `sys_rst` is held.

// File: rtl/ecc_seq_pkg.sv
package ecc_seq_pkg;
  localparam int DW = 16;
  localparam int CW = 22;

  typedef enum logic [2:0] {
    CT_NONE  = 3'd0,
    CT_READ  = 3'd1,
    CT_WRITE = 3'd2,
    CT_RMW   = 3'd3,
    CT_REF   = 3'd4
  } cyc_t;

  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic doe;
    logic lat;
    logic last;
  } step_ctl_t;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          single;
    logic          dbl;
  } dec_t;

  // data bits live at every position that is not a power of two
  function automatic logic [DW-1:0] cw_data(logic [CW-1:0] c);
    logic [DW-1:0] d;
    logic [3:0]    k;
    d = '0;
    k = '0;
    for (int p = 3; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = c[p[4:0]];
        k    = k + 4'd1;
      end
    end
    return d;
  endfunction

  function automatic logic [CW-1:0] ecc_encode(logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic [3:0]    k;
    logic [4:0]    syn;
    c   = '0;
    k   = '0;
    syn = '0;
    for (int p = 3; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p[4:0]] = d[k];
        if (d[k]) syn = syn ^ p[4:0];
        k = k + 4'd1;
      end
    end
    c[1]  = syn[0];
    c[2]  = syn[1];
    c[4]  = syn[2];
    c[8]  = syn[3];
    c[16] = syn[4];
    c[0]  = ^c[CW-1:1];
    return c;
  endfunction

  function automatic dec_t ecc_decode(logic [CW-1:0] c);
    dec_t          r;
    logic [4:0]    syn;
    logic          ov;
    logic [CW-1:0] f;
    syn = '0;
    for (int p = 1; p < CW; p++)
      if (c[p[4:0]]) syn = syn ^ p[4:0];
    ov = ^c;
    f  = c;
    if (ov && syn < 5'(CW)) f[syn] = ~f[syn];
    r.data   = cw_data(f);
    r.single = ov && (syn < 5'(CW));
    r.dbl    = (!ov && syn != 5'd0) || (ov && syn >= 5'(CW));
    return r;
  endfunction
endpackage

// File: rtl/ecc_seq_arb.sv
module ecc_seq_arb
  import ecc_seq_pkg::*;
#(
  parameter int REF_INT = 64
) (
  input  logic clk,
  input  logic por,
  input  logic sys_rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic req_byte,
  input  logic slot,
  output logic accept,
  output logic launch,
  output cyc_t launch_typ,
  output logic busy
);
  localparam int TW = (REF_INT > 1) ? $clog2(REF_INT) : 1;

  logic [TW-1:0] tmr_q;
  logic          ref_pend_q, host_pend_q, host_run_q;
  cyc_t          host_typ_q;
  logic          tmr_hit;

  assign tmr_hit    = (tmr_q == TW'(REF_INT - 1));
  assign busy       = host_pend_q | host_run_q;
  assign accept     = req_valid && !busy && !sys_rst;
  // refresh outranks any waiting host request
  assign launch     = slot && (ref_pend_q || (host_pend_q && !sys_rst));
  assign launch_typ = ref_pend_q ? CT_REF : host_typ_q;

  always_ff @(posedge clk) begin
    if (por) begin
      tmr_q       <= '0;
      ref_pend_q  <= 1'b0;
      host_pend_q <= 1'b0;
      host_run_q  <= 1'b0;
      host_typ_q  <= CT_NONE;
    end else begin
      tmr_q <= tmr_hit ? '0 : tmr_q + 1'b1;
      if (tmr_hit)                            ref_pend_q <= 1'b1;
      else if (launch && launch_typ == CT_REF) ref_pend_q <= 1'b0;

      if (sys_rst) begin
        host_pend_q <= 1'b0;
      end else if (accept) begin
        host_pend_q <= 1'b1;
        host_typ_q  <= !req_write ? CT_READ : (req_byte ? CT_RMW : CT_WRITE);
      end else if (launch && !ref_pend_q) begin
        host_pend_q <= 1'b0;
      end

      if (slot) host_run_q <= launch && !ref_pend_q;
    end
  end
endmodule

// File: rtl/ecc_seq_stepper.sv
module ecc_seq_stepper
  import ecc_seq_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_PRE = 2,
  parameter int T_REF = 3
) (
  input  logic      clk,
  input  logic      por,
  input  logic      launch,
  input  cyc_t      launch_typ,
  output logic      slot,
  output cyc_t      typ,
  output step_ctl_t ctl
);
  localparam int TMAX = (T_RCD > T_CAS ? T_RCD : T_CAS) > (T_PRE > T_REF ? T_PRE : T_REF)
                      ? (T_RCD > T_CAS ? T_RCD : T_CAS) : (T_PRE > T_REF ? T_PRE : T_REF);
  localparam int DUR_W = $clog2(TMAX + 1);

  logic             act_q;
  logic [2:0]       stp_q;
  logic [DUR_W-1:0] cnt_q;

  function automatic logic [DUR_W-1:0] dur_tab(cyc_t t, logic [2:0] s);
    int d;
    d = 1;
    case (t)
      CT_READ:  case (s) 3'd0: d = T_RCD; 3'd1: d = T_CAS; 3'd3: d = T_PRE; default: d = 1; endcase
      CT_WRITE: case (s) 3'd0: d = T_RCD; 3'd2: d = T_CAS; 3'd3: d = T_PRE; default: d = 1; endcase
      CT_RMW:   case (s) 3'd0: d = T_RCD; 3'd1: d = T_CAS; 3'd5: d = T_CAS; 3'd6: d = T_PRE;
                         default: d = 1; endcase
      CT_REF:   d = (s == 3'd0) ? T_REF : T_PRE;
      default:  d = 1;
    endcase
    return DUR_W'(d);
  endfunction

  function automatic step_ctl_t ctl_tab(cyc_t t, logic [2:0] s);
    step_ctl_t c;
    c = '0;
    case (t)
      CT_READ: case (s)
        3'd0:    c.ras = 1'b1;
        3'd1:    begin c.ras = 1'b1; c.cas = 1'b1; end
        3'd2:    begin c.ras = 1'b1; c.cas = 1'b1; c.lat = 1'b1; end
        default: c.last = 1'b1;
      endcase
      CT_WRITE: case (s)
        3'd0:    c.ras = 1'b1;
        3'd1:    begin c.ras = 1'b1; c.doe = 1'b1; end
        3'd2:    begin c.ras = 1'b1; c.cas = 1'b1; c.we = 1'b1; c.doe = 1'b1; end
        default: c.last = 1'b1;
      endcase
      CT_RMW: case (s)
        3'd0, 3'd3: c.ras = 1'b1;
        3'd1:    begin c.ras = 1'b1; c.cas = 1'b1; end
        3'd2:    begin c.ras = 1'b1; c.cas = 1'b1; c.lat = 1'b1; end
        3'd4:    begin c.ras = 1'b1; c.doe = 1'b1; end
        3'd5:    begin c.ras = 1'b1; c.cas = 1'b1; c.we = 1'b1; c.doe = 1'b1; end
        default: c.last = 1'b1;
      endcase
      CT_REF: begin
        c.ras  = (s == 3'd0);
        c.last = (s != 3'd0);
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  assign slot = !act_q || (cnt_q == DUR_W'(1) && ctl.last);

  always_ff @(posedge clk) begin
    if (por) begin
      act_q <= 1'b0;
      typ   <= CT_NONE;
      stp_q <= '0;
      cnt_q <= '0;
      ctl   <= '0;
    end else if (slot) begin
      act_q <= launch;
      typ   <= launch ? launch_typ : CT_NONE;
      stp_q <= '0;
      cnt_q <= launch ? dur_tab(launch_typ, 3'd0) : '0;
      ctl   <= launch ? ctl_tab(launch_typ, 3'd0) : '0;
    end else if (cnt_q == DUR_W'(1)) begin
      stp_q <= stp_q + 3'd1;
      cnt_q <= dur_tab(typ, stp_q + 3'd1);
      ctl   <= ctl_tab(typ, stp_q + 3'd1);
    end else begin
      cnt_q <= cnt_q - DUR_W'(1);
    end
  end
endmodule

// File: rtl/ecc_dram_seq.sv
module ecc_dram_seq
  import ecc_seq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 4,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_PRE   = 2,
  parameter int T_REF   = 3,
  parameter int REF_INT = 64,
  localparam int AW     = BANK_W + ROW_W + COL_W,
  localparam int NB     = 1 << BANK_W
) (
  input  logic             clk,
  input  logic             por,
  input  logic             sys_rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_byte,
  input  logic             req_hi,
  input  logic [AW-1:0]    req_addr,
  input  logic [15:0]      req_wdata,
  input  logic             cfg_we,
  input  logic             cfg_ecc_en,
  output logic             busy,
  output logic             rd_valid,
  output logic [15:0]      rd_data,
  output logic             err_corr,
  output logic             err_uncorr,
  output logic [NB-1:0]    dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic [ROW_W-1:0] dram_row,
  output logic [COL_W-1:0] dram_col,
  output logic [21:0]      dram_wdata,
  output logic             dram_dout_en,
  input  logic [21:0]      dram_rdata
);
  logic      slot, accept, launch;
  cyc_t      launch_typ, typ;
  step_ctl_t ctl;

  logic [AW-1:0]    addr_q;
  logic [15:0]      wd_q;
  logic             hi_q, ecc_on, lat_d;
  logic [CW-1:0]    rd_cw, wr_cw;
  logic [ROW_W-1:0] ref_row;
  dec_t             dec;
  logic [15:0]      rd_word, merged;

  ecc_seq_arb #(.REF_INT(REF_INT)) u_arb (
    .clk(clk), .por(por), .sys_rst(sys_rst), .req_valid(req_valid),
    .req_write(req_write), .req_byte(req_byte), .slot(slot), .accept(accept),
    .launch(launch), .launch_typ(launch_typ), .busy(busy)
  );

  ecc_seq_stepper #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_PRE(T_PRE), .T_REF(T_REF)) u_step (
    .clk(clk), .por(por), .launch(launch), .launch_typ(launch_typ),
    .slot(slot), .typ(typ), .ctl(ctl)
  );

  always_comb begin
    dec     = ecc_decode(rd_cw);
    rd_word = ecc_on ? dec.data : cw_data(rd_cw);
    merged  = hi_q ? {wd_q[15:8], rd_word[7:0]} : {rd_word[15:8], wd_q[7:0]};
  end

  always_ff @(posedge clk) begin
    if (por) begin
      addr_q     <= '0;
      wd_q       <= '0;
      hi_q       <= 1'b0;
      ecc_on     <= 1'b0;
      lat_d      <= 1'b0;
      rd_cw      <= '0;
      wr_cw      <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      err_corr   <= 1'b0;
      err_uncorr <= 1'b0;
      ref_row    <= '0;
    end else begin
      if (accept) begin
        addr_q <= req_addr;
        wd_q   <= req_wdata;
        hi_q   <= req_hi;
        wr_cw  <= ecc_encode(req_wdata);
      end
      lat_d <= ctl.lat;
      if (ctl.lat) rd_cw <= dram_rdata;
      rd_valid <= lat_d && typ == CT_READ;
      if (lat_d && typ == CT_READ) rd_data <= rd_word;
      if (lat_d && typ == CT_RMW)  wr_cw <= ecc_encode(merged);
      if (cfg_we) begin
        ecc_on     <= cfg_ecc_en;
        err_corr   <= 1'b0;
        err_uncorr <= 1'b0;
      end else if (lat_d && ecc_on) begin
        err_corr   <= err_corr | dec.single;
        err_uncorr <= err_uncorr | dec.dbl;
      end
      if (slot && typ == CT_REF) ref_row <= ref_row + 1'b1;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_ras
    assign dram_ras_n[b] = !(ctl.ras && (typ == CT_REF || addr_q[BANK_W-1:0] == BANK_W'(b)));
  end

  assign dram_cas_n   = !ctl.cas;
  assign dram_we_n    = !ctl.we;
  assign dram_dout_en = ctl.doe;
  assign dram_wdata   = wr_cw;
  assign dram_row     = (typ == CT_REF) ? ref_row : addr_q[AW-1 -: ROW_W];
  assign dram_col     = addr_q[BANK_W +: COL_W];
endmodule

// File: rtl/ecc_dram_seq_chk.sv
module ecc_dram_seq_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          por,
  input logic          sys_rst,
  input logic          cfg_we,
  input logic          busy,
  input logic          err_corr,
  input logic          err_uncorr,
  input logic          ecc_on,
  input logic [NB-1:0] dram_ras_n,
  input logic          dram_cas_n,
  input logic          dram_we_n,
  input logic          dram_dout_en
);
  // R7
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (por)
    !dram_cas_n |-> (dram_ras_n != '1));
  // R7
  we_inside_drive_chk: assert property (@(posedge clk) disable iff (por)
    !dram_we_n |-> (dram_dout_en && !dram_cas_n));
  // R8
  refresh_no_cas_chk: assert property (@(posedge clk) disable iff (por)
    (dram_ras_n == '0) |-> dram_cas_n);
  // R9
  single_bank_chk: assert property (@(posedge clk) disable iff (por)
    (dram_ras_n != '0) |-> $onehot0(~dram_ras_n));
  // R3
  corr_sticky_chk: assert property (@(posedge clk) disable iff (por)
    (err_corr && !cfg_we) |=> err_corr);
  // R4
  uncorr_sticky_chk: assert property (@(posedge clk) disable iff (por)
    (err_uncorr && !cfg_we) |=> err_uncorr);
  // R5
  flag_needs_ecc_chk: assert property (@(posedge clk) disable iff (por)
    ($rose(err_corr) || $rose(err_uncorr)) |-> ecc_on);
  // R8
  reset_holds_idle_chk: assert property (@(posedge clk) disable iff (por)
    (sys_rst && !busy) |=> !busy);
endmodule

bind ecc_dram_seq ecc_dram_seq_chk #(.NB(NB)) u_chk (
  .clk(clk), .por(por), .sys_rst(sys_rst), .cfg_we(cfg_we), .busy(busy),
  .err_corr(err_corr), .err_uncorr(err_uncorr), .ecc_on(ecc_on),
  .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
  .dram_dout_en(dram_dout_en)
);

// File: tb/tb_ecc_dram_seq.sv
module tb_ecc_dram_seq;
  localparam int TCAS = 2;
  localparam int RINT = 64;
  localparam int NBK  = 4;

  logic        clk = 1'b0;
  logic        por = 1'b1, sys_rst = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0, req_hi = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        cfg_we = 1'b0, cfg_ecc_en = 1'b0;
  logic        busy, rd_valid, err_corr, err_uncorr, dram_cas_n, dram_we_n, dram_dout_en;
  logic [15:0] rd_data;
  logic [3:0]  dram_ras_n, dram_row, dram_col;
  logic [21:0] dram_wdata, dram_rdata;

  ecc_dram_seq #(.T_CAS(TCAS), .REF_INT(RINT)) dut (
    .clk(clk), .por(por), .sys_rst(sys_rst), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .req_hi(req_hi), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_we(cfg_we), .cfg_ecc_en(cfg_ecc_en), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .err_corr(err_corr), .err_uncorr(err_uncorr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_row(dram_row), .dram_col(dram_col), .dram_wdata(dram_wdata),
    .dram_dout_en(dram_dout_en), .dram_rdata(dram_rdata)
  );

  always #4ns clk = ~clk;

  // behavioural array
  logic [21:0] mem [0:1023];
  logic [3:0]  row_lat [0:NBK-1];
  logic [3:0]  ras_prev = 4'hF;
  logic [15:0] shadow [0:1023];

  function automatic logic [1:0] act_bank(logic [3:0] r);
    for (int b = 0; b < NBK; b++) if (!r[b]) return 2'(b);
    return 2'd0;
  endfunction

  function automatic logic [9:0] idx(logic [9:0] a);
    return {a[1:0], a[9:6], a[5:2]};
  endfunction

  assign dram_rdata = mem[{act_bank(dram_ras_n), row_lat[act_bank(dram_ras_n)], dram_col}];

  always @(posedge clk) begin
    for (int b = 0; b < NBK; b++)
      if (ras_prev[b] && !dram_ras_n[b]) row_lat[b] <= dram_row;
    ras_prev <= dram_ras_n;
    if (!dram_cas_n && !dram_we_n && dram_ras_n != 4'h0)
      mem[{act_bank(dram_ras_n), row_lat[act_bank(dram_ras_n)], dram_col}] <= dram_wdata;
  end

  // strobe monitors
  int   runs [0:3];
  bit   rwe  [0:3];
  int   nrun = 0, cur = 0, ref_cnt = 0;
  bit   cur_we = 0, all_prev = 0;
  logic [1:0] last_bank = '0;

  always @(negedge clk) begin
    if (!dram_cas_n) begin
      cur++;
      if (!dram_we_n) cur_we = 1;
      last_bank = act_bank(dram_ras_n);
    end else if (cur > 0) begin
      if (nrun < 4) begin runs[nrun] = cur; rwe[nrun] = cur_we; end
      nrun++;
      cur = 0;
      cur_we = 0;
    end
    if (dram_ras_n == 4'h0 && !all_prev) ref_cnt++;
    all_prev = (dram_ras_n == 4'h0);
  end

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic issue(bit wr, bit byt, bit hi, logic [9:0] a, logic [15:0] d);
    @(negedge clk);
    wait_idle();
    nrun = 0;
    req_valid = 1; req_write = wr; req_byte = byt; req_hi = hi; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic write_word(logic [9:0] a, logic [15:0] d);
    issue(1, 0, 0, a, d);
    wait_idle();
    shadow[a] = d;
  endtask

  task automatic write_byte(logic [9:0] a, bit hi, logic [7:0] b);
    issue(1, 1, hi, a, {b, b});
    wait_idle();
    if (hi) shadow[a][15:8] = b; else shadow[a][7:0] = b;
  endtask

  task automatic read_word(logic [9:0] a, output logic [15:0] d);
    issue(0, 0, 0, a, 16'h0);
    d = 16'hxxxx;
    for (int i = 0; i < 400; i++) begin
      if (rd_valid) begin d = rd_data; break; end
      @(negedge clk);
    end
    wait_idle();
  endtask

  task automatic set_ecc(bit on);
    @(negedge clk);
    wait_idle();
    cfg_we = 1; cfg_ecc_en = on;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    logic [15:0] d, w;
    logic [9:0]  a;
    int          p, q, base;
    void'($urandom(32'd5171));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    por = 0;
    @(negedge clk);
    // R1
    check("R1 ras", dram_ras_n, 4'hF);
    check("R1 cas/we", {dram_cas_n, dram_we_n}, 2'b11);
    check("R1 busy/flags", {busy, err_corr, err_uncorr}, 3'b000);

    // R2 R7 R9: random word writes and reads, correction off
    for (int i = 0; i < 12; i++) begin
      a = 10'($urandom); w = 16'($urandom);
      write_word(a, w);
      check("R7 write pulse", {nrun[3:0], runs[0][3:0], 3'(rwe[0])}, {4'd1, 4'(TCAS), 3'd1});
      read_word(a, d);
      check("R2 readback", d, w);
      check("R7 read pulse", {nrun[3:0], runs[0][3:0], 3'(rwe[0])}, {4'd1, 4'(TCAS + 1), 3'd0});
      check("R9 bank", last_bank, a[1:0]);
    end

    // R6 byte writes with correction on
    set_ecc(1);
    for (int i = 0; i < 10; i++) begin
      a = 10'($urandom);
      write_word(a, 16'($urandom));
      write_byte(a, 1'($urandom), 8'($urandom));
      check("R7 rmw pulses", {nrun[3:0], runs[0][3:0], 3'(rwe[0]), runs[1][3:0], 3'(rwe[1])},
            {4'd2, 4'(TCAS + 1), 3'd0, 4'(TCAS), 3'd1});
      read_word(a, d);
      check("R6 merged", d, shadow[a]);
      check("R6 no flags", {err_corr, err_uncorr}, 2'b00);
    end
    // directed corners on both lanes
    write_word(10'h3FF, 16'hA55A);
    write_byte(10'h3FF, 0, 8'hFF);
    read_word(10'h3FF, d);
    check("R6 low lane", d, 16'hA5FF);
    write_byte(10'h3FF, 1, 8'h00);
    read_word(10'h3FF, d);
    check("R6 high lane", d, 16'h00FF);

    // R3 single error corrected, sticky
    for (int i = 0; i < 6; i++) begin
      set_ecc(1);
      a = 10'($urandom); w = 16'($urandom); p = $urandom_range(21, 0);
      write_word(a, w);
      mem[idx(a)][p] = ~mem[idx(a)][p];
      read_word(a, d);
      check("R3 corrected", d, w);
      check("R3 flags", {err_corr, err_uncorr}, 2'b10);
      mem[idx(a)][p] = ~mem[idx(a)][p];
      read_word(a, d);
      check("R3 sticky", err_corr, 1'b1);
    end
    set_ecc(1);
    check("R3 cleared by control write", err_corr, 1'b0);

    // R4 double error
    for (int i = 0; i < 4; i++) begin
      set_ecc(1);
      a = 10'($urandom); w = 16'($urandom);
      p = $urandom_range(21, 0); q = (p + 1 + $urandom_range(20, 0)) % 22;
      write_word(a, w);
      mem[idx(a)][p] = ~mem[idx(a)][p];
      mem[idx(a)][q] = ~mem[idx(a)][q];
      read_word(a, d);
      check("R4 flags", {err_corr, err_uncorr}, 2'b01);
      write_word(a, w);
      read_word(a, d);
      check("R4 sticky", err_uncorr, 1'b1);
    end

    // R5 correction off: raw data, no flags
    set_ecc(0);
    a = 10'h155; w = 16'h1234;
    write_word(a, w);
    mem[idx(a)][3] = ~mem[idx(a)][3];
    read_word(a, d);
    check("R5 raw data bit0", d, w ^ 16'h0001);
    check("R5 no flags", {err_corr, err_uncorr}, 2'b00);
    mem[idx(a)][0] = ~mem[idx(a)][0];
    mem[idx(a)][16] = ~mem[idx(a)][16];
    read_word(a, d);
    check("R5 no flags double", {err_corr, err_uncorr}, 2'b00);
    write_word(a, w);

    // R8 refresh idle and under system reset
    base = ref_cnt;
    repeat (3 * RINT) @(negedge clk);
    check("R8 idle refresh", 32'(ref_cnt - base >= 2), 32'd1);
    base = ref_cnt;
    sys_rst = 1;
    req_valid = 1; req_write = 0; req_addr = 10'h001;
    for (int i = 0; i < 4 * RINT; i++) begin
      @(negedge clk);
      if (busy) break;
    end
    check("R8 host dropped", busy, 1'b0);
    req_valid = 0;
    check("R8 refresh during reset", 32'(ref_cnt - base >= 3), 32'd1);
    sys_rst = 0;

    // R10 contents survive
    read_word(a, d);
    check("R10 survive", d, w);
    read_word(10'h3FF, d);
    check("R10 survive 2", d, 16'h00FF);

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule